// File: doc/BRIEF.md
# Dual-Byte-Strobe DRAM Control Decoder

This block is the control front end of a 16-bit asynchronous DRAM model. It watches the five active-low strobe pins (row strobe, the two byte column strobes, write enable and output enable) and the multiplexed address pins. It samples all of them with a fast clock and turns each memory cycle into clean one-clock control events. Those events are a merged column strobe, a read enable for each byte lane, a write strobe for each byte lane, row and column latch pulses, and a data-capture pulse. An operation code tells the storage side what kind of cycle is in progress.

The kind of cycle is set only by the order of the strobe edges. If the row strobe falls while no column strobe is low, a row is opened. That cycle stays a row-only refresh until a column strobe falls. If a column strobe was already low when the row strobe falls, the cycle is a refresh driven by an internal row counter. If that refresh is held long enough, it becomes self refresh, which ends only after the row strobe has been high for a set time. The internal row counter steps once at the end of every counter-driven refresh.

Top module: `dram_strobe_decoder`

## Requirements
- R1: `cas_int` is 1 while either byte strobe is low and 0 only when both are high. It asserts on the first fall of the two and releases on the last rise.
- R2: `lane_oe[0]` is 1 only when the row strobe, the lower strobe and the output enable are all low and write enable is high, during an access cycle (op 4, 1 or 2). `lane_oe[1]` follows the same rule with the upper strobe.
- R3: Op becomes READ (1) in the sample where the later of the column-strobe fall and the output-enable fall completes the read condition, while write enable is high.
- R4: `lane_wr[i]` pulses for exactly one cycle when lane i's strobe and write enable are both low during an access cycle. The pulse comes at the later of the two falls, and op becomes WRITE (2) in the same cycle. Bit 0 of `lane_wr` is the lower lane and bit 1 is the upper lane.
- R5: `din_capture` pulses once per column cycle, at the earlier of the merged column-strobe fall and the write-enable fall.
- R6: A row-strobe fall while a column strobe was already low in the previous sample decodes counter refresh (op 3). `row_addr` keeps its value, no row latch pulses, and both lane enables and write strobes stay 0.
- R7: A row-strobe fall with both column strobes high pulses `row_latch` for one cycle, loads `row_addr` from `addr`, and reports row-only refresh (op 4) until an access begins.
- R8: A merged column-strobe fall during an access cycle pulses `col_latch` for one cycle and loads `col_addr` from `addr`.
- R9: While the row strobe is high and self refresh is not active, op is standby (0) and both lane enables are 0.
- R10: Op becomes self refresh (5) after the row strobe has stayed low for TRAS_CYC cycles in counter refresh. Self refresh returns to standby only after the row strobe has been high for TRP_CYC cycles.
- R11: `ref_row` is 0 after reset. It steps by one, modulo 2^ADDR_W, when the row strobe rises at the end of a counter refresh or of self refresh.
- R12: A row-strobe fall and a column-strobe fall seen in the same sample count as simultaneous. They decode an access with both row and column latch pulses, not a refresh.
- R13: After reset every output is 0 and op is standby. A pin change reaches the outputs on the third rising clock edge after it is set up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe pin, active low |
| lcas_n | input | 1 | Lower-byte column strobe pin, active low |
| ucas_n | input | 1 | Upper-byte column strobe pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| addr | input | ADDR_W | Multiplexed row/column address pins |
| cas_int | output | 1 | Merged column strobe, active high |
| lane_oe | output | 2 | Per-lane data drive enables (bit 0 lower, bit 1 upper) |
| lane_wr | output | 2 | Per-lane one-cycle write strobes |
| din_capture | output | 1 | One-cycle input data capture pulse |
| row_latch | output | 1 | One-cycle row address latch pulse |
| col_latch | output | 1 | One-cycle column address latch pulse |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Latched column address |
| op | output | 3 | 0 standby, 1 read, 2 write, 3 counter refresh, 4 row-only refresh, 5 self refresh |
| ref_row | output | ADDR_W | Internal refresh row counter |

## Verification
A wrong decode of the edge order shows on `op` three clocks after the offending edge. A refresh mistaken for an access also shows there as a spurious `row_latch` or a nonzero `lane_oe` while op reads 3. A lost or extra lane strobe appears as a missing or repeated one-cycle `lane_wr` or `din_capture` pulse, so the bench samples those pulses in their exact cycle and in the cycle after. Faults in the self-refresh timers or the refresh counter stay hidden until a refresh ends. The bench therefore probes the op code one cycle either side of each window boundary and runs the row counter through a full wrap.

// File: rtl/dsd_pkg.sv
`timescale 1ns/1ps
package dsd_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_CBR   = 3'd3,
        OP_RONLY = 3'd4,
        OP_SELF  = 3'd5
    } op_e;
endpackage

// File: rtl/dsd_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer bank for asynchronous pins.
module dsd_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/dsd_refresh_ctr.sv
`timescale 1ns/1ps
// Internal refresh row counter, wraps modulo 2**W.
module dsd_refresh_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] row
);
    logic [W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (step) row_d = row_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;
endmodule

// File: rtl/dram_strobe_decoder.sv
`timescale 1ns/1ps
module dram_strobe_decoder #(
    parameter int ADDR_W   = 10,
    parameter int TRAS_CYC = 16,
    parameter int TRP_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cas_int,
    output logic [1:0]        lane_oe,
    output logic [1:0]        lane_wr,
    output logic              din_capture,
    output logic              row_latch,
    output logic              col_latch,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic [2:0]        op,
    output logic [ADDR_W-1:0] ref_row
);
    import dsd_pkg::*;

    localparam int CNT_MAX = (TRAS_CYC > TRP_CYC) ? TRAS_CYC : TRP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int NPIN    = 5;

    // Active-high pin bundle: {ras, lcas, ucas, we, oe}
    typedef struct packed {
        logic ras;
        logic lc;
        logic uc;
        logic we;
        logic oe;
    } pins_t;

    typedef struct packed {
        op_e               op;
        logic [CNT_W-1:0]  cnt;
        pins_t             prev;
        logic              capt;
        logic              cas;
        logic [1:0]        lane_oe;
        logic [1:0]        lane_wr;
        logic              din_cap;
        logic              row_le;
        logic              col_le;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
    } st_t;

    localparam st_t ST_RST = '{op: OP_IDLE, default: '0};

    logic [NPIN-1:0]   pins_n_s;
    logic [ADDR_W-1:0] addr_s;
    pins_t             cur;
    st_t               s_q, s_d;
    logic              ref_step;

    dsd_sync #(.W(NPIN), .RST_VAL({NPIN{1'b1}})) u_sync_ctl (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ras_n, lcas_n, ucas_n, we_n, oe_n}),
        .dout (pins_n_s)
    );

    dsd_sync #(.W(ADDR_W), .RST_VAL('0)) u_sync_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (addr),
        .dout (addr_s)
    );

    assign cur = pins_t'(~pins_n_s);

    always_comb begin
        logic [1:0] lane_now, lane_was;
        logic       cas_now, cas_was, ras_fall, ras_rise;
        logic       cas_fall, we_fall, acc, rd_now, rd_was;

        s_d         = s_q;
        s_d.prev    = cur;
        s_d.row_le  = 1'b0;
        s_d.col_le  = 1'b0;
        s_d.din_cap = 1'b0;
        s_d.lane_wr = 2'b00;
        ref_step    = 1'b0;

        lane_now = {cur.uc, cur.lc};
        lane_was = {s_q.prev.uc, s_q.prev.lc};
        cas_now  = |lane_now;
        cas_was  = |lane_was;
        ras_fall = cur.ras & ~s_q.prev.ras;
        ras_rise = ~cur.ras & s_q.prev.ras;
        cas_fall = cas_now & ~cas_was;
        we_fall  = cur.we & ~s_q.prev.we;

        // Cycle classification by edge order
        if (ras_fall) begin
            if (s_q.op == OP_SELF) begin
                s_d.cnt = '0;
            end else if (cas_was) begin
                s_d.op  = OP_CBR;
                s_d.cnt = '0;
            end else begin
                s_d.op     = OP_RONLY;
                s_d.row_le = 1'b1;
                s_d.row    = addr_s;
            end
        end else if (!cur.ras) begin
            if (ras_rise && (s_q.op == OP_CBR || s_q.op == OP_SELF)) ref_step = 1'b1;
            if (s_q.op == OP_SELF) begin
                if (s_q.cnt == CNT_W'(TRP_CYC - 1)) s_d.op  = OP_IDLE;
                else                                 s_d.cnt = s_q.cnt + CNT_W'(1);
            end else begin
                s_d.op = OP_IDLE;
            end
        end else begin
            if (s_q.op == OP_CBR) begin
                if (s_q.cnt == CNT_W'(TRAS_CYC - 1)) begin
                    s_d.op  = OP_SELF;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end else if (s_q.op == OP_SELF) begin
                s_d.cnt = '0;
            end
        end

        // Access events
        acc    = cur.ras && (s_d.op == OP_RONLY || s_d.op == OP_READ || s_d.op == OP_WRITE);
        rd_now = cur.ras & cas_now & cur.oe & ~cur.we;
        rd_was = s_q.prev.ras & cas_was & s_q.prev.oe & ~s_q.prev.we;

        if (acc) begin
            if (cas_fall) begin
                s_d.col_le = 1'b1;
                s_d.col    = addr_s;
            end
            if ((cas_fall || we_fall) && !s_q.capt) s_d.din_cap = 1'b1;
            if (rd_now && !rd_was) s_d.op = OP_READ;
        end

        for (int i = 0; i < 2; i++) begin
            if (acc && lane_now[i] && cur.we &&
                !(lane_was[i] && s_q.prev.we && s_q.prev.ras)) begin
                s_d.lane_wr[i] = 1'b1;
                s_d.op         = OP_WRITE;
            end
            s_d.lane_oe[i] = acc & lane_now[i] & cur.oe & ~cur.we;
        end

        if (!cur.ras || (!cas_now && !cur.we)) s_d.capt = 1'b0;
        else if (s_d.din_cap)                  s_d.capt = 1'b1;

        s_d.cas = cas_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= ST_RST;
        else        s_q <= s_d;
    end

    dsd_refresh_ctr #(.W(ADDR_W)) u_ref (
        .clk  (clk),
        .rst_n(rst_n),
        .step (ref_step),
        .row  (ref_row)
    );

    assign cas_int     = s_q.cas;
    assign lane_oe     = s_q.lane_oe;
    assign lane_wr     = s_q.lane_wr;
    assign din_capture = s_q.din_cap;
    assign row_latch   = s_q.row_le;
    assign col_latch   = s_q.col_le;
    assign row_addr    = s_q.row;
    assign col_addr    = s_q.col;
    assign op          = s_q.op;
endmodule

// File: rtl/dsd_checker.sv
`timescale 1ns/1ps
module dsd_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cas_int,
    input logic [1:0]        lane_oe,
    input logic [1:0]        lane_wr,
    input logic              row_latch,
    input logic [ADDR_W-1:0] row_addr,
    input logic [2:0]        op,
    input logic [ADDR_W-1:0] ref_row
);
    // R1: a driving lane implies the merged strobe is active
    p_lane_needs_cas_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_oe) |-> cas_int);

    // R2: lanes drive only in a read
    p_lane_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_oe) |-> (op == 3'd1));

    // R4: write strobe comes with write op and lasts one cycle
    p_wr_with_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_wr) |-> (op == 3'd2));
    p_wr_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_wr) |=> ((lane_wr & $past(lane_wr)) == 2'b00));

    // R6: refresh keeps lanes quiet and the row latch untouched
    p_refresh_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 || op == 3'd5 || op == 3'd0) |-> (lane_oe == 2'b00 && lane_wr == 2'b00));
    p_refresh_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 && $past(op) == 3'd3) |-> ($stable(row_addr) && !row_latch));

    // R10: self refresh is entered only from counter refresh
    p_self_from_cbr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5 && $past(op) != 3'd5) |-> ($past(op) == 3'd3));

    // R11: the refresh counter moves by one step only
    p_ref_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_row != $past(ref_row)) |-> (ref_row == $past(ref_row) + ADDR_W'(1)));
endmodule

bind dram_strobe_decoder dsd_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_dram_strobe_decoder.sv
`timescale 1ns/1ps
module tb_dram_strobe_decoder;
    localparam int AW   = 10;
    localparam int TRAS = 16;
    localparam int TRP  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cas_int, din_capture, row_latch, col_latch;
    logic [1:0]    lane_oe, lane_wr;
    logic [AW-1:0] row_addr, col_addr, ref_row;
    logic [2:0]    op;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dram_strobe_decoder #(.ADDR_W(AW), .TRAS_CYC(TRAS), .TRP_CYC(TRP)) dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .cas_int(cas_int), .lane_oe(lane_oe),
        .lane_wr(lane_wr), .din_capture(din_capture), .row_latch(row_latch),
        .col_latch(col_latch), .row_addr(row_addr), .col_addr(col_addr), .op(op),
        .ref_row(ref_row)
    );

    // pins = {ras_n, lcas_n, ucas_n, we_n, oe_n}
    typedef struct packed {
        logic [4:0]    pins;
        logic [AW-1:0] a;
        logic [2:0]    e_op;
        logic [1:0]    e_lane;
        logic          e_cas;
        logic [AW-1:0] e_row;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{5'b11111, 10'h000, 3'd0, 2'b00, 1'b0, 10'h000},  // R9 standby
        '{5'b01111, 10'h155, 3'd4, 2'b00, 1'b0, 10'h155},  // R7 row open
        '{5'b00010, 10'h0AA, 3'd1, 2'b11, 1'b1, 10'h155},  // R3 word read
        '{5'b00110, 10'h0AA, 3'd1, 2'b01, 1'b1, 10'h155},  // R2 lower lane only
        '{5'b01010, 10'h0AA, 3'd1, 2'b10, 1'b1, 10'h155},  // R2 upper lane only
        '{5'b01110, 10'h0AA, 3'd1, 2'b00, 1'b0, 10'h155},  // R1 both strobes high
        '{5'b00100, 10'h0AA, 3'd2, 2'b00, 1'b1, 10'h155},  // R4 page write
        '{5'b11111, 10'h000, 3'd0, 2'b00, 1'b0, 10'h155},  // R9
        '{5'b10111, 10'h000, 3'd0, 2'b00, 1'b1, 10'h155},  // R1 strobe low, row high
        '{5'b00110, 10'h3FF, 3'd3, 2'b00, 1'b1, 10'h155},  // R6 counter refresh
        '{5'b11111, 10'h000, 3'd0, 2'b00, 1'b0, 10'h155}   // R11 end of refresh
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] p, input logic [AW-1:0] a);
        @(negedge clk);
        {ras_n, lcas_n, ucas_n, we_n, oe_n} = p;
        addr = a;
    endtask

    // Land on the exact cycle in which a pin change shows at the outputs
    task automatic step3();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 op in reset", int'(op), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 outputs after reset", int'({cas_int, lane_oe, lane_wr, din_capture, row_latch, col_latch}), 0);
        chk("R13 row_addr after reset", int'(row_addr), 0);
        chk("R11 ref_row after reset", int'(ref_row), 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            drive(TBL[v].pins, TBL[v].a);
            settle();
            chk($sformatf("R9/R3/R6 op vec%0d", v), int'(op), int'(TBL[v].e_op));
            chk($sformatf("R2 lane_oe vec%0d", v), int'(lane_oe), int'(TBL[v].e_lane));
            chk($sformatf("R1 cas_int vec%0d", v), int'(cas_int), int'(TBL[v].e_cas));
            chk($sformatf("R6 row_addr vec%0d", v), int'(row_addr), int'(TBL[v].e_row));
        end
        chk("R11 ref_row after one refresh", int'(ref_row), 1);

        // R7/R8/R13: row open then read with exact pulse timing
        drive(5'b01111, 10'h2C3);
        step3();
        chk("R7 row_latch pulse", int'(row_latch), 1);
        chk("R13 op latency", int'(op), 4);
        chk("R7 row_addr", int'(row_addr), 'h2C3);
        @(negedge clk);
        chk("R7 row_latch one cycle", int'(row_latch), 0);
        settle();
        drive(5'b00110, 10'h01F);
        step3();
        chk("R8 col_latch pulse", int'(col_latch), 1);
        chk("R5 capture on strobe fall", int'(din_capture), 1);
        chk("R3 read op", int'(op), 1);
        chk("R8 col_addr", int'(col_addr), 'h01F);
        @(negedge clk);
        chk("R8 col_latch one cycle", int'(col_latch), 0);
        drive(5'b11111, 10'h000);
        settle();
        chk("R7 row-only then standby", int'(op), 0);

        // R4/R5: early write, enable falls before the upper strobe
        drive(5'b01111, 10'h011);
        settle();
        drive(5'b01101, 10'h011);
        step3();
        chk("R5 capture on enable fall", int'(din_capture), 1);
        chk("R4 no strobe before lane", int'(lane_wr), 0);
        settle();
        drive(5'b01001, 10'h022);
        step3();
        chk("R4 upper write strobe", int'(lane_wr), 2);
        chk("R5 no second capture", int'(din_capture), 0);
        chk("R4 write op", int'(op), 2);
        @(negedge clk);
        chk("R4 strobe one cycle", int'(lane_wr), 0);
        drive(5'b11111, 10'h000);
        settle();

        // R4/R5: late write, lower strobe before enable
        drive(5'b01111, 10'h033);
        settle();
        drive(5'b00111, 10'h033);
        step3();
        chk("R5 capture at lower fall", int'(din_capture), 1);
        chk("R4 no strobe with enable high", int'(lane_wr), 0);
        settle();
        drive(5'b00101, 10'h033);
        step3();
        chk("R4 lower write strobe", int'(lane_wr), 1);
        chk("R5 no capture at later fall", int'(din_capture), 0);
        drive(5'b11111, 10'h000);
        settle();

        // R12: simultaneous row and column fall
        drive(5'b00110, 10'h044);
        step3();
        chk("R12 decoded as read", int'(op), 1);
        chk("R12 row latch", int'(row_latch), 1);
        chk("R12 col latch", int'(col_latch), 1);
        chk("R12 lower lane drives", int'(lane_oe), 1);
        drive(5'b11111, 10'h000);
        settle();

        // R10/R11: self refresh entry and exit
        drive(5'b10111, 10'h000);
        settle();
        drive(5'b00111, 10'h155);
        step3();
        chk("R6 counter refresh op", int'(op), 3);
        chk("R6 no row latch in refresh", int'(row_latch), 0);
        repeat (TRAS - 2) @(negedge clk);
        chk("R10 not yet self refresh", int'(op), 3);
        repeat (3) @(negedge clk);
        chk("R10 self refresh entered", int'(op), 5);
        repeat (20) @(negedge clk);
        chk("R10 self refresh held", int'(op), 5);
        chk("R6 row_addr unchanged", int'(row_addr), 'h044);
        drive(5'b11111, 10'h000);
        repeat (TRP) @(negedge clk);
        chk("R10 exit waits for precharge", int'(op), 5);
        repeat (3) @(negedge clk);
        chk("R10 exit to standby", int'(op), 0);
        chk("R11 step after self refresh", int'(ref_row), 2);

        // R11: wrap of the refresh counter
        drive(5'b10111, 10'h000);
        settle();
        for (int k = 0; k < 1022; k++) begin
            drive(5'b00111, 10'h000);
            repeat (5) @(negedge clk);
            drive(5'b10111, 10'h000);
            repeat (5) @(negedge clk);
            if (k == 1020) chk("R11 counter at top", int'(ref_row), 1023);
        end
        chk("R11 counter wraps", int'(ref_row), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule